// File: doc/BRIEF.md
# Serial Configuration Bitstream Streamer

This block is the logic core of a serial configuration memory. It holds a fixed bitstream of `BITS` bits in an internal read-only array, keeps an address counter, and shifts the stored bits out one per configuration clock into a downstream programmable device. That device captures each bit on the rising edge of the configuration clock, so the serial output changes only at the edge that advances the address.

The block runs in one of two modes, chosen by `slave_i`. As a master it derives the configuration clock from the system clock through a divider and drives it out. As a chained slave it takes the configuration clock from the previous device, resynchronises it, and advances on its rising edges. An active-high enable input doubles as an active-low clear for the counter. An active-low select pauses the stream without losing position. When all bits have gone out, a done flag latches and the data pin takes a parameter-selected idle state.

Top module: `cfg_streamer`

## Requirements
- R1: In master mode `cclk_o` toggles every `DIV` cycles of `clk_i` while the stream runs. Each rising edge of `cclk_o` advances the address by one in the same `clk_i` cycle, and `data_o` changes in that cycle too. The value on `data_o` just before the k-th rising edge (k counted from 1) is stored bit k-1. Stored bit a is the XOR reduction of the `ADDR_W`-bit value (a XOR `SEED`), with `ADDR_W` = ceil(log2(`BITS`+1)).
- R2: The address advances only while `oe_i` is high, `cs_ni` is low and `done_o` is low. Raising `cs_ni` freezes the address. After `cs_ni` falls again, the stream resumes with the next unsent bit, so no bit is lost or repeated.
- R3: `oe_i` low clears the address and `done_o` at the next `clk_i` edge. When `oe_i` is high again, `data_o` shows bit 0 and the next stream starts from bit 0.
- R4: `data_oe_o` is low whenever `cs_ni` is high or `oe_i` is low.
- R5: In master mode `cclk_oe_o` is high, and `cclk_o` is low from the first `clk_i` edge after `oe_i` goes low.
- R6: Exactly `BITS` rising configuration clock edges are consumed. `done_o` rises at the `clk_i` edge of the last one. From the next `clk_i` edge onward, `cclk_o` stays low for as long as `done_o` holds.
- R7: `done_o` stays high, whatever happens on `cs_ni` or `cclk_i`, until `oe_i` goes low.
- R8: While `done_o` is high, `oe_i` is high and `cs_ni` is low, the data pin follows `DONE_HIGH`. With `DONE_HIGH`=1 it is driven: `data_oe_o`=1 and `data_o`=1. With `DONE_HIGH`=0 it floats: `data_oe_o`=0.
- R9: In slave mode `cclk_oe_o` and `cclk_o` are low. Each rising edge on `cclk_i` advances the address. The `clk_i` edge that first samples `cclk_i` high is followed by two more `clk_i` edges, and the address changes at the second of these.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_i | input | 1 | 0: master, drives the configuration clock; 1: slave, takes `cclk_i` |
| oe_i | input | 1 | High enables output and counting; low clears the address and done |
| cs_ni | input | 1 | Chip select, active low; high pauses and floats data |
| cclk_i | input | 1 | Configuration clock from the previous device (slave mode) |
| cclk_o | output | 1 | Configuration clock driven in master mode |
| cclk_oe_o | output | 1 | Drive enable for `cclk_o` |
| data_o | output | 1 | Serial configuration data |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| done_o | output | 1 | All `BITS` bits have been sent |

## Verification
In master mode the address, `data_o` and the rising edge of `cclk_o` all change at one `clk_i` edge. The bench therefore samples every output at the falling edge of `clk_i` and takes the bit sent on each configuration clock rise from the sample one falling edge earlier. The enable, clear and pin-drive effects of `oe_i` and `cs_ni` are due one `clk_i` edge after the input changes (combinational for the drive enables), and they are read at the next falling edge. In slave mode a `cclk_i` rise takes effect three `clk_i` edges after the falling edge that drives it. The bench checks `done_o` exactly at the second and third falling edges after the final pulse, so that the latency is fixed to one cycle.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  typedef enum logic {
    SRC_DIVIDER = 1'b0,
    SRC_CHAIN   = 1'b1
  } clk_src_e;

  // Stored pattern: parity of (addr ^ seed) over the low 'width' bits
  function automatic logic pattern_bit(input int unsigned addr,
                                       input int unsigned seed,
                                       input int unsigned width);
    logic        p;
    int unsigned v;
    p = 1'b0;
    v = addr ^ seed;
    for (int i = 0; i < 32; i++) begin
      if (i < int'(width)) p = p ^ v[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/cfg_clk_div.sv
module cfg_clk_div #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o,
  output logic rise_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             clk_q;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!run_i) begin
      // source halted: park low, restart a full half period
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o  = clk_q;
  assign rise_o = run_i & wrap & ~clk_q;

endmodule

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
  parameter int unsigned BITS   = 64,
  parameter int unsigned ADDR_W = $clog2(BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BITS - 1);

  logic [ADDR_W-1:0] addr_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (step_i && !done_q) begin
      addr_q <= addr_q + 1'b1;
      if (addr_q == LAST) done_q <= 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;

endmodule

// File: rtl/cfg_rom.sv
module cfg_rom #(
  parameter int unsigned BITS   = 64,
  parameter int unsigned ADDR_W = $clog2(BITS + 1),
  parameter int unsigned SEED   = 32'h35
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bit_o
);
  localparam int unsigned IDX_W = $clog2(BITS);

  logic [BITS-1:0] mem;

  for (genvar g = 0; g < BITS; g++) begin : g_bit
    assign mem[g] = cfg_stream_pkg::pattern_bit(g, SEED, ADDR_W);
  end

  assign bit_o = (addr_i < ADDR_W'(BITS)) ? mem[addr_i[IDX_W-1:0]] : 1'b0;

endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer #(
  parameter int unsigned BITS        = 64,
  parameter int unsigned DIV         = 2,
  parameter int unsigned SEED        = 32'h35,
  parameter bit          DONE_HIGH   = 1'b1,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = $clog2(BITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slave_i,
  input  logic oe_i,
  input  logic cs_ni,
  input  logic cclk_i,
  output logic cclk_o,
  output logic cclk_oe_o,
  output logic data_o,
  output logic data_oe_o,
  output logic done_o
);
  import cfg_stream_pkg::*;

  clk_src_e          src;
  logic              run;
  logic              gen_clk, gen_rise, ext_rise, step;
  logic              rom_bit;
  logic              done_q;
  logic [ADDR_W-1:0] addr_q;

  assign src = slave_i ? SRC_CHAIN : SRC_DIVIDER;
  assign run = oe_i & ~cs_ni & ~done_q;

  cfg_clk_div #(.DIV(DIV)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run & (src == SRC_DIVIDER)),
    .clk_o  (gen_clk),
    .rise_o (gen_rise)
  );

  cfg_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cclk_i),
    .rise_o (ext_rise)
  );

  assign step = run & ((src == SRC_CHAIN) ? ext_rise : gen_rise);

  cfg_addr_ctr #(.BITS(BITS), .ADDR_W(ADDR_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~oe_i),
    .step_i (step),
    .addr_o (addr_q),
    .done_o (done_q)
  );

  cfg_rom #(.BITS(BITS), .ADDR_W(ADDR_W), .SEED(SEED)) i_rom (
    .addr_i (addr_q),
    .bit_o  (rom_bit)
  );

  assign cclk_o    = (src == SRC_DIVIDER) & gen_clk;
  assign cclk_oe_o = (src == SRC_DIVIDER);
  assign data_o    = oe_i & (done_q ? DONE_HIGH : rom_bit);
  assign data_oe_o = oe_i & ~cs_ni & (~done_q | DONE_HIGH);
  assign done_o    = done_q;

endmodule

// File: rtl/cfg_streamer_chk.sv
module cfg_streamer_chk #(
  parameter int unsigned BITS      = 64,
  parameter int unsigned ADDR_W    = 7,
  parameter bit          DONE_HIGH = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slave_i,
  input logic              oe_i,
  input logic              cs_ni,
  input logic              cclk_o,
  input logic              cclk_oe_o,
  input logic              data_o,
  input logic              data_oe_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] addr_q
);

  // R1: address moves by at most one per clk_i edge while enabled
  a_r1_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |=> (addr_q == $past(addr_q)) || (addr_q == $past(addr_q) + 1'b1));

  // R1: data only changes with address, enable or done
  a_r1_data_tracks_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(addr_q) && $stable(oe_i) && $stable(done_o)) |-> $stable(data_o));

  // R2: no count while deselected
  a_r2_hold_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && oe_i) |=> addr_q == $past(addr_q));

  // R3: enable low clears state
  a_r3_oe_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> (addr_q == '0) && !done_o);

  // R4: data floats when deselected or disabled
  a_r4_data_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || !oe_i) |-> !data_oe_o);

  // R5: clock parks low after enable drops
  a_r5_clk_low_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> !cclk_o);

  // R6: counter bound and clock idle after completion
  a_r6_addr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= ADDR_W'(BITS));

  a_r6_clk_idle_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> !cclk_o);

  // R7: done is sticky while enabled
  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && oe_i) |=> done_o);

  // R8: idle data pin rule after completion
  a_r8_done_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && oe_i && !cs_ni) |->
      (data_oe_o == DONE_HIGH) && (data_o == DONE_HIGH));

  // R9: slave never drives the clock pin
  a_r9_slave_no_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_i |-> (!cclk_oe_o && !cclk_o));

endmodule

bind cfg_streamer cfg_streamer_chk #(
  .BITS      (BITS),
  .ADDR_W    (ADDR_W),
  .DONE_HIGH (DONE_HIGH)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .slave_i   (slave_i),
  .oe_i      (oe_i),
  .cs_ni     (cs_ni),
  .cclk_o    (cclk_o),
  .cclk_oe_o (cclk_oe_o),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .done_o    (done_o),
  .addr_q    (addr_q)
);

// File: tb/test_cfg_streamer.sv
module test_cfg_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int BITS       = 64;
  localparam int DIV        = 2;
  localparam int SEED       = 32'h35;
  localparam int ADDR_W     = $clog2(BITS + 1);
  localparam int CAP_N      = BITS + 16;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave = 1'b0, oe = 1'b0, cs_n = 1'b1, cclk_in = 1'b0;
  logic cclk_o, cclk_oe_o, data_o, data_oe_o, done_o;
  logic cclk_t, cclk_oe_t, data_t, data_oe_t, done_t;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic mon_on = 1'b0;
  logic prev_c, prev_d;
  logic cap [0:CAP_N-1];
  int   cap_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_streamer #(.BITS(BITS), .DIV(DIV), .SEED(SEED), .DONE_HIGH(1'b1)) i_cfg_streamer (
    .clk_i(clk), .rst_ni(rst_n), .slave_i(slave), .oe_i(oe), .cs_ni(cs_n),
    .cclk_i(cclk_in), .cclk_o(cclk_o), .cclk_oe_o(cclk_oe_o),
    .data_o(data_o), .data_oe_o(data_oe_o), .done_o(done_o));

  cfg_streamer #(.BITS(BITS), .DIV(DIV), .SEED(SEED), .DONE_HIGH(1'b0)) i_cfg_streamer_tri (
    .clk_i(clk), .rst_ni(rst_n), .slave_i(slave), .oe_i(oe), .cs_ni(cs_n),
    .cclk_i(cclk_in), .cclk_o(cclk_t), .cclk_oe_o(cclk_oe_t),
    .data_o(data_t), .data_oe_o(data_oe_t), .done_o(done_t));

  function automatic logic exp_bit(input int a);
    int v, ones;
    v = (a ^ SEED) & ((1 << ADDR_W) - 1);
    ones = 0;
    while (v != 0) begin
      ones += v % 2;
      v = v / 2;
    end
    return logic'(ones % 2);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // record the bit presented just before each cclk_o rise
  always @(negedge clk) begin
    if (mon_on) begin
      if (cclk_o && !prev_c && cap_n < CAP_N) begin
        cap[cap_n] = prev_d;
        cap_n++;
      end
      prev_c = cclk_o;
      prev_d = data_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic master_stream(input int abort_at, input int pause_pct);
    @(posedge clk);
    cap_n = 0; prev_c = 1'b0; prev_d = 1'b0; mon_on = 1'b1;
    @(negedge clk);
    slave = 1'b0; cs_n = 1'b0; oe = 1'b1;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (done_o) break;
      if (c == abort_at) begin
        oe = 1'b0;
        break;
      end
      if (cs_n) chk(!data_oe_o && !data_oe_t, "R4 data_oe while deselected", data_oe_o, 0);
      if ($urandom_range(99) < pause_pct) cs_n = ~cs_n;
    end
    cs_n = 1'b0;
  endtask

  task automatic check_capture(input int n_exp, input string req);
    chk(cap_n == n_exp, req, cap_n, n_exp);
    for (int i = 0; i < cap_n && i < BITS; i++)
      chk(cap[i] == exp_bit(i), "R1 bit order", cap[i], exp_bit(i));
  endtask

  task automatic slave_stream(input int cs_pct);
    int hi, lo;
    @(negedge clk);
    oe = 1'b0; slave = 1'b1; cs_n = 1'b0; cclk_in = 1'b0;
    @(negedge clk);
    chk(!data_oe_o, "R4 data_oe with oe low", data_oe_o, 0);
    oe = 1'b1;
    @(negedge clk);
    chk(!cclk_oe_o && !cclk_o, "R9 slave clock pin idle", cclk_oe_o, 0);
    for (int k = 0; k < BITS; k++) begin
      chk(data_o == exp_bit(k), "R9 slave bit", data_o, exp_bit(k));
      if ($urandom_range(99) < cs_pct) begin
        cs_n = 1'b1;
        cclk_in = 1'b1; wait_neg(3);
        cclk_in = 1'b0; wait_neg(3);
        cs_n = 1'b0;
        @(negedge clk);
        chk(data_o == exp_bit(k), "R2 pulse ignored while deselected", data_o, exp_bit(k));
      end
      cclk_in = 1'b1;
      if (k == BITS - 1) begin
        wait_neg(2);
        chk(!done_o, "R9 latency early", done_o, 0);
        @(negedge clk);
        chk(done_o, "R9 latency due", done_o, 1);
        wait_neg(1);
      end else begin
        hi = $urandom_range(4, 1);
        wait_neg(hi);
      end
      cclk_in = 1'b0;
      lo = $urandom_range(4, 2);
      wait_neg(lo);
    end
    for (int p = 0; p < 3; p++) begin
      cclk_in = 1'b1; wait_neg(3);
      cclk_in = 1'b0; wait_neg(3);
    end
    chk(done_o && data_o && data_oe_o, "R7 done holds after extra pulses", done_o, 1);
    chk(!data_oe_t, "R8 float after done (slave)", data_oe_t, 0);
  endtask

  initial begin
    int abort_at;
    void'($urandom(32'd20240611));

    wait_neg(3);
    chk(!done_o && !data_oe_o && !cclk_o, "R4 reset state", {done_o, data_oe_o, cclk_o}, 0);
    rst_n = 1'b1;
    wait_neg(2);
    chk(cclk_oe_o, "R5 master drives clock pin", cclk_oe_o, 1);
    chk(!data_oe_o, "R4 float with oe low", data_oe_o, 0);

    // aborted stream: oe drop mid-way
    abort_at = $urandom_range(150, 30);
    master_stream(abort_at, 5);
    @(negedge clk);
    chk(!cclk_o, "R5 clock low after oe low", cclk_o, 0);
    chk(!done_o && !data_oe_o, "R3 cleared by oe low", done_o, 0);
    check_capture(cap_n, "R1 prefix count");
    wait_neg(2);
    mon_on = 1'b0;

    // full streams with varying pause density
    for (int run = 0; run < 3; run++) begin
      master_stream(-1, (run == 0) ? 0 : 4 + 6 * run);
      wait_neg(3);
      chk(done_o, "R6 done after stream", done_o, 1);
      chk(!cclk_o, "R6 clock idle after done", cclk_o, 0);
      chk(data_oe_o && data_o, "R8 drive high after done", data_o, 1);
      chk(!data_oe_t, "R8 float after done", data_oe_t, 0);
      if (cap_n > 0) chk(cap[0] == exp_bit(0), "R3 stream starts at bit 0", cap[0], exp_bit(0));
      check_capture(BITS, "R6 rising edge count");
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (i == 10) cs_n = 1'b1;
        if (i == 20) cs_n = 1'b0;
        if (cclk_o || !done_o) chk(0, "R7 done/clock idle hold", {done_o, cclk_o}, 2);
      end
      chk(cap_n == BITS, "R2 no extra bits after done", cap_n, BITS);
      mon_on = 1'b0;
      oe = 1'b0;
      @(negedge clk);
      chk(!done_o, "R7 done cleared by oe low", done_o, 0);
      chk(!data_oe_o, "R4 float with oe low", data_oe_o, 0);
      oe = 1'b1;
      @(negedge clk);
      chk(data_o == exp_bit(0), "R3 restart shows bit 0", data_o, exp_bit(0));
      oe = 1'b0;
      wait_neg(2);
    end

    // chained slave mode
    slave_stream(0);
    slave_stream(25);
    @(negedge clk);
    oe = 1'b0; slave = 1'b0;
    @(negedge clk);
    chk(cclk_oe_o && !cclk_o, "R5 master clock pin after mode return", cclk_oe_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule